// File: doc/BRIEF.md
# Configurable Framing Serial Transmitter

This block turns bytes written by a host into asynchronous serial frames. A single-cycle write strobe captures a byte in a holding register. On the next clock the byte moves into a 16-entry first-in first-out queue. A framing engine takes bytes from the queue one at a time. It wraps each byte in a start bit, a programmable number of data bits, an optional parity bit and a stop field, and drives the result onto a single line.

The bit rate comes from outside the block. An external divider supplies a one-cycle tick at sixteen times the bit rate, and every bit on the line lasts sixteen ticks. A set of static line-control inputs selects the frame shape: word length, parity on or off, odd or even parity, and one or two stop bits. The engine captures these settings at the start of each frame.

The host watches the queue level, the empty and full flags, a sticky overrun flag and a transmitter-empty flag. It uses these to pace its writes and to tell when the line has gone quiet.

Top module: `sertx_top`

## Requirements
- R1: After reset the line output is 1, the queue level is 0, the queue-empty and transmitter-empty flags are 1, and the full and overrun flags are 0. Whenever the engine is idle the line is 1.
- R2: Every frame opens with a start bit of 0 that lasts one bit period.
- R3: Data bits follow the start bit, least significant bit first. Their count is set by `cfg_wlen`: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Byte bits above the word length are not sent.
- R4: When `cfg_par_en` is 1, one parity bit follows the data bits. With `cfg_par_odd` at 0 the data bits plus the parity bit hold an even number of ones; with it at 1 they hold an odd number. When `cfg_par_en` is 0, no parity bit is sent.
- R5: A stop field of value 1 ends each frame. It is one bit long, or two bits long when `cfg_stop2` is 1.
- R6: The queue holds up to 16 bytes and sends them in write order. `fifo_level` reports how many bytes are queued, `fifo_full` is 1 exactly at 16, and `fifo_empty` is 1 exactly at 0.
- R7: A byte that reaches a full queue is discarded, and `tx_overrun` is set. The flag stays at 1 until reset.
- R8: If another byte is queued when a stop field ends, the next start bit begins in that same cycle. Consecutive frames leave no idle time between them.
- R9: `tx_empty` is 1 only while the holding register is empty, the queue is empty and the engine is idle. It stays 0 during a frame even after the queue has drained.
- R10: The line-control inputs are sampled when a byte is taken for sending. Changing them in the middle of a frame does not change that frame.
- R11: A bit period is 16 `bit_tick` pulses. While a frame is in progress and no tick arrives, the line output does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe, one byte per high cycle |
| wr_data | input | 8 | Byte to send |
| bit_tick | input | 1 | Oversampling tick, 16 per bit period |
| cfg_wlen | input | 2 | Word length code (00=5 .. 11=8 bits) |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_stop2 | input | 1 | 1 selects two stop bits |
| ser_out | output | 1 | Serial line |
| fifo_level | output | 5 | Number of queued bytes |
| fifo_empty | output | 1 | Queue holds no bytes |
| fifo_full | output | 1 | Queue holds 16 bytes |
| tx_overrun | output | 1 | Sticky flag: a write was dropped |
| tx_empty | output | 1 | Nothing held, queued or being sent |

## Verification
The properties assume the following about the inputs:
- `bit_tick` is a single-cycle pulse at most every other cycle.
- Reset is applied before any traffic.
- Writes arrive as one-cycle strobes.

The bench generates the tick itself on alternate cycles, so a bit period is exactly 32 clocks after the first tick. It keeps `wr_en` to clean strobes. It changes the line-control inputs only where the mid-frame sampling rule (R10) is being exercised. Frame boundaries on the line are measured against the 31- or 32-cycle length of the first start bit, which depends on the tick phase at the moment of the pop.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP   = 3'd4
    } eng_state_e;

    typedef struct packed {
        logic [1:0] wlen;
        logic       par_en;
        logic       par_odd;
        logic       stop2;
    } line_cfg_t;

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          fifo_full,
    output logic          push,
    output logic [DW-1:0] push_data,
    output logic          hold_valid,
    output logic          overrun
);

    typedef struct packed {
        logic          valid;
        logic [DW-1:0] data;
        logic          ovf;
    } hold_t;

    hold_t s_q, s_d;

    always_comb begin
        s_d       = s_q;
        s_d.valid = wr_en;
        if (wr_en) begin
            s_d.data = wr_data;
        end
        if (s_q.valid && fifo_full) begin
            s_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign push       = s_q.valid && !fifo_full;
    assign push_data  = s_q.data;
    assign hold_valid = s_q.valid;
    assign overrun    = s_q.ovf;

endmodule

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
    parameter  int DEPTH = 16,
    parameter  int DW    = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [DW-1:0]    push_data,
    input  logic             pop,
    output logic [DW-1:0]    pop_data,
    output logic [LVL_W-1:0] level,
    output logic             empty,
    output logic             full
);

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [LVL_W-1:0] count;
    } fifo_t;

    fifo_t s_q, s_d;
    logic [DW-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_comb begin
        s_d = s_q;
        if (do_push) begin
            s_d.wptr = ptr_inc(s_q.wptr);
        end
        if (do_pop) begin
            s_d.rptr = ptr_inc(s_q.rptr);
        end
        case ({do_push, do_pop})
            2'b10:   s_d.count = s_q.count + 1'b1;
            2'b01:   s_d.count = s_q.count - 1'b1;
            default: s_d.count = s_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem_q[s_q.wptr] <= push_data;
        end
    end

    assign pop_data = mem_q[s_q.rptr];
    assign level    = s_q.count;
    assign empty    = (s_q.count == '0);
    assign full     = (s_q.count == LVL_W'(DEPTH));

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
#(
    parameter  int OVS   = 16,
    localparam int CNT_W = (OVS > 1) ? $clog2(OVS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  line_cfg_t         cfg,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_data,
    output logic              pop,
    output logic              ser_out,
    output eng_state_e        state
);

    typedef struct packed {
        eng_state_e        st;
        logic [CNT_W-1:0]  tcnt;
        logic [2:0]        bcnt;
        logic [DATA_W-1:0] shreg;
        logic              par;
        line_cfg_t         cfg;
        logic              ser;
    } eng_t;

    eng_t s_q, s_d;

    logic              last_tick;
    logic [3:0]        nbits_q;
    logic [3:0]        nbits_in;
    logic [DATA_W-1:0] mask_in;
    logic [DATA_W-1:0] masked;

    assign last_tick = tick && (s_q.tcnt == CNT_W'(OVS - 1));
    assign nbits_q   = 4'd5 + {2'b00, s_q.cfg.wlen};
    assign nbits_in  = 4'd5 + {2'b00, cfg.wlen};

    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            mask_in[i] = (i < int'(nbits_in));
        end
        masked = fifo_data & mask_in;
    end

    always_comb begin
        s_d = s_q;
        pop = 1'b0;

        if (s_q.st != ST_IDLE && tick) begin
            s_d.tcnt = last_tick ? '0 : s_q.tcnt + 1'b1;
        end

        case (s_q.st)
            ST_IDLE: begin
                if (!fifo_empty) begin
                    pop       = 1'b1;
                    s_d.st    = ST_START;
                    s_d.tcnt  = '0;
                    s_d.bcnt  = '0;
                    s_d.shreg = masked;
                    s_d.par   = (^masked) ^ cfg.par_odd;
                    s_d.cfg   = cfg;
                end
            end
            ST_START: begin
                if (last_tick) begin
                    s_d.st   = ST_DATA;
                    s_d.bcnt = '0;
                end
            end
            ST_DATA: begin
                if (last_tick) begin
                    s_d.shreg = s_q.shreg >> 1;
                    if (s_q.bcnt == 3'(nbits_q - 4'd1)) begin
                        s_d.bcnt = '0;
                        s_d.st   = s_q.cfg.par_en ? ST_PARITY : ST_STOP;
                    end else begin
                        s_d.bcnt = s_q.bcnt + 1'b1;
                    end
                end
            end
            ST_PARITY: begin
                if (last_tick) begin
                    s_d.st   = ST_STOP;
                    s_d.bcnt = '0;
                end
            end
            ST_STOP: begin
                if (last_tick) begin
                    if (s_q.bcnt == {2'b00, s_q.cfg.stop2}) begin
                        if (!fifo_empty) begin
                            pop       = 1'b1;
                            s_d.st    = ST_START;
                            s_d.bcnt  = '0;
                            s_d.shreg = masked;
                            s_d.par   = (^masked) ^ cfg.par_odd;
                            s_d.cfg   = cfg;
                        end else begin
                            s_d.st = ST_IDLE;
                        end
                    end else begin
                        s_d.bcnt = s_q.bcnt + 1'b1;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase

        case (s_d.st)
            ST_START:  s_d.ser = 1'b0;
            ST_DATA:   s_d.ser = s_d.shreg[0];
            ST_PARITY: s_d.ser = s_d.par;
            default:   s_d.ser = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.st  <= ST_IDLE;
            s_q.ser <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign ser_out = s_q.ser;
    assign state   = s_q.st;

endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter  int DEPTH = 16,
    parameter  int OVS   = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             bit_tick,
    input  logic [1:0]       cfg_wlen,
    input  logic             cfg_par_en,
    input  logic             cfg_par_odd,
    input  logic             cfg_stop2,
    output logic             ser_out,
    output logic [LVL_W-1:0] fifo_level,
    output logic             fifo_empty,
    output logic             fifo_full,
    output logic             tx_overrun,
    output logic             tx_empty
);

    line_cfg_t         cfg;
    logic              push;
    logic [DATA_W-1:0] push_data;
    logic              hold_valid;
    logic              pop;
    logic [DATA_W-1:0] pop_data;
    eng_state_e        eng_state;

    assign cfg = '{wlen: cfg_wlen, par_en: cfg_par_en,
                   par_odd: cfg_par_odd, stop2: cfg_stop2};

    sertx_hold #(.DW(DATA_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .fifo_full  (fifo_full),
        .push       (push),
        .push_data  (push_data),
        .hold_valid (hold_valid),
        .overrun    (tx_overrun)
    );

    sertx_fifo #(.DEPTH(DEPTH), .DW(DATA_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .pop_data  (pop_data),
        .level     (fifo_level),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    sertx_shifter #(.OVS(OVS)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (bit_tick),
        .cfg        (cfg),
        .fifo_empty (fifo_empty),
        .fifo_data  (pop_data),
        .pop        (pop),
        .ser_out    (ser_out),
        .state      (eng_state)
    );

    assign tx_empty = fifo_empty && !hold_valid && (eng_state == ST_IDLE);

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk
    import sertx_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_tick,
    input logic             ser_out,
    input eng_state_e       state,
    input logic             fifo_empty,
    input logic             fifo_full,
    input logic [LVL_W-1:0] fifo_level,
    input logic             tx_overrun,
    input logic             tx_empty
);

    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> ser_out);

    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_START |-> !ser_out);

    a_r5_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_STOP |-> ser_out);

    a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));

    a_r6_full_level: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> fifo_level == LVL_W'(DEPTH));

    a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        tx_overrun |=> tx_overrun);

    a_r8_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && !fifo_empty) |=> (state == ST_STOP || state == ST_START));

    a_r9_empty_means_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> (fifo_empty && state == ST_IDLE));

    a_r11_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_tick && state != ST_IDLE) |=> $stable(ser_out));

endmodule

bind sertx_top sertx_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_tick   (bit_tick),
    .ser_out    (ser_out),
    .state      (eng_state),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full),
    .fifo_level (fifo_level),
    .tx_overrun (tx_overrun),
    .tx_empty   (tx_empty)
);

// File: tb/sertx_top_tb_top.sv
module sertx_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int BIT_CYC    = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       bit_tick = 1'b0;
    logic       tick_en = 1'b1;
    logic [1:0] cfg_wlen = 2'b11;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_stop2 = 1'b0;
    logic       ser_out;
    logic [4:0] fifo_level;
    logic       fifo_empty;
    logic       fifo_full;
    logic       tx_overrun;
    logic       tx_empty;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    sertx_top dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .bit_tick    (bit_tick),
        .cfg_wlen    (cfg_wlen),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .cfg_stop2   (cfg_stop2),
        .ser_out     (ser_out),
        .fifo_level  (fifo_level),
        .fifo_empty  (fifo_empty),
        .fifo_full   (fifo_full),
        .tx_overrun  (tx_overrun),
        .tx_empty    (tx_empty)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        forever begin
            @(negedge clk);
            bit_tick = tick_en ? ~bit_tick : 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic set_cfg(input logic [1:0] wl, input bit pe, input bit po, input bit s2);
        cfg_wlen = wl; cfg_par_en = pe; cfg_par_odd = po; cfg_stop2 = s2;
    endtask

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Receives one frame from the line; checks start, parity and stop fields.
    task automatic recv(input int nb, input bit pe, input bit po, input bit s2,
                        output logic [7:0] d, output int t0);
        int guard = 0;
        logic pbit;
        d = '0;
        while (ser_out !== 1'b0 && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        t0 = cyc;
        repeat (BIT_CYC / 2) @(negedge clk);
        check(ser_out == 1'b0, "R2", "start bit mid value", ser_out, 0);
        for (int i = 0; i < nb; i++) begin
            repeat (BIT_CYC) @(negedge clk);
            d[i] = ser_out;
        end
        if (pe) begin
            repeat (BIT_CYC) @(negedge clk);
            pbit = ser_out;
            check(pbit == ((^d) ^ po), "R4", "parity bit", pbit, (^d) ^ po);
        end
        repeat (BIT_CYC) @(negedge clk);
        check(ser_out == 1'b1, "R5", "first stop bit", ser_out, 1);
        if (s2) begin
            repeat (BIT_CYC) @(negedge clk);
            check(ser_out == 1'b1, "R5", "second stop bit", ser_out, 1);
        end
    endtask

    task automatic wait_quiet();
        int guard = 0;
        while (tx_empty !== 1'b1 && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic t_reset();
        check(ser_out == 1'b1, "R1", "line after reset", ser_out, 1);
        check(fifo_level == 0, "R1", "level after reset", fifo_level, 0);
        check(fifo_empty == 1'b1, "R1", "empty after reset", fifo_empty, 1);
        check(fifo_full == 1'b0, "R1", "full after reset", fifo_full, 0);
        check(tx_empty == 1'b1, "R1", "tx_empty after reset", tx_empty, 1);
        check(tx_overrun == 1'b0, "R1", "overrun after reset", tx_overrun, 0);
    endtask

    // One frame with a given shape; data must arrive LSB first, masked to the word length.
    task automatic t_frame(input logic [1:0] wl, input bit pe, input bit po, input bit s2,
                           input logic [7:0] b);
        logic [7:0] got;
        logic [7:0] exp;
        int t0;
        int nb = 5 + int'(wl);
        exp = b & 8'((1 << nb) - 1);
        set_cfg(wl, pe, po, s2);
        fork
            write_byte(b);
            recv(nb, pe, po, s2, got, t0);
        join
        check(got == exp, "R3", "received data", got, exp);
        check(tx_empty == 1'b0, "R9", "tx_empty during stop field", tx_empty, 0);
        wait_quiet();
        check(ser_out == 1'b1, "R1", "line idle after frame", ser_out, 1);
    endtask

    task automatic t_start_len();
        int guard = 0;
        int low = 0;
        set_cfg(2'b11, 1'b0, 1'b0, 1'b0);
        write_byte(8'h01);
        while (ser_out !== 1'b0 && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        check(fifo_empty == 1'b1 && tx_empty == 1'b0, "R9", "tx_empty while sending",
              tx_empty, 0);
        while (ser_out === 1'b0 && low < 200) begin
            @(negedge clk);
            low++;
        end
        check(low == BIT_CYC || low == BIT_CYC - 1, "R2", "start bit length", low, BIT_CYC);
        wait_quiet();
    endtask

    task automatic t_back_to_back();
        logic [7:0] g0, g1;
        int t0, t1;
        int span = (1 + 6 + 2) * BIT_CYC;
        set_cfg(2'b01, 1'b0, 1'b0, 1'b1);
        fork
            begin write_byte(8'h2D); write_byte(8'h12); end
            begin recv(6, 0, 0, 1, g0, t0); recv(6, 0, 0, 1, g1, t1); end
        join
        check(g0 == 8'h2D && g1 == 8'h12, "R6", "order of two frames", g1, 8'h12);
        check((t1 - t0) == span || (t1 - t0) == span - 1, "R8", "start-to-start spacing",
              t1 - t0, span);
        wait_quiet();
    endtask

    task automatic t_cfg_midframe();
        logic [7:0] got;
        int t0;
        set_cfg(2'b11, 1'b0, 1'b0, 1'b0);
        fork
            write_byte(8'h96);
            recv(8, 0, 0, 0, got, t0);
            begin
                repeat (45) @(negedge clk);
                set_cfg(2'b00, 1'b1, 1'b0, 1'b1);
            end
        join
        check(got == 8'h96, "R10", "frame unaffected by config change", got, 8'h96);
        wait_quiet();
        check(tx_empty == 1'b1, "R10", "quiet after frame", tx_empty, 1);
        set_cfg(2'b11, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_tick_pause();
        int guard = 0;
        bit held = 1'b1;
        set_cfg(2'b11, 1'b0, 1'b0, 1'b0);
        write_byte(8'h00);
        while (ser_out !== 1'b0 && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        repeat (10) @(negedge clk);
        tick_en = 1'b0;
        repeat (100) begin
            @(negedge clk);
            if (ser_out !== 1'b0) held = 1'b0;
        end
        check(held, "R11", "line held without ticks", held, 1);
        check(tx_empty == 1'b0, "R11", "frame still pending", tx_empty, 0);
        tick_en = 1'b1;
        wait_quiet();
        check(ser_out == 1'b1, "R11", "frame completes after resume", ser_out, 1);
    endtask

    task automatic t_overflow();
        logic [7:0] got;
        int t0;
        bit order_ok = 1'b1;
        set_cfg(2'b11, 1'b0, 1'b0, 1'b0);
        fork
            begin
                @(negedge clk);
                for (int i = 0; i < 18; i++) begin
                    wr_en = 1'b1; wr_data = 8'(i * 7 + 1);
                    @(negedge clk);
                end
                wr_en = 1'b0;
                repeat (3) @(negedge clk);
                check(fifo_level == 16, "R6", "level when full", fifo_level, 16);
                check(fifo_full == 1'b1, "R6", "full flag", fifo_full, 1);
                check(tx_overrun == 1'b1, "R7", "overrun set", tx_overrun, 1);
            end
            begin
                for (int i = 0; i < 17; i++) begin
                    recv(8, 0, 0, 0, got, t0);
                    if (got != 8'(i * 7 + 1)) begin
                        order_ok = 1'b0;
                        check(1'b0, "R6", "queued byte value", got, i * 7 + 1);
                    end
                end
            end
        join
        check(order_ok, "R6", "all 17 bytes in order", order_ok, 1);
        wait_quiet();
        repeat (100) @(negedge clk);
        check(ser_out == 1'b1 && tx_empty == 1'b1, "R7", "dropped byte never sent",
              ser_out, 1);
        check(tx_overrun == 1'b1, "R7", "overrun still set", tx_overrun, 1);
        check(fifo_empty == 1'b1 && fifo_level == 0, "R6", "queue drained", fifo_level, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_frame(2'b11, 0, 0, 0, 8'hA5);
        t_frame(2'b00, 0, 0, 0, 8'hF3);
        t_frame(2'b10, 1, 0, 0, 8'h35);
        t_frame(2'b01, 1, 1, 1, 8'h2A);
        t_frame(2'b11, 1, 1, 0, 8'h00);
        t_start_len();
        t_back_to_back();
        t_cfg_midframe();
        t_tick_pause();
        t_overflow();
        finish_run();
    end

endmodule